// File: doc/BRIEF.md
# Lockable Security Register Bank

This block holds a set of security-critical 16-bit configuration registers, such as key material or memory-protection settings. Access to them is governed by a separate group of lock-configuration registers. Trusted boot firmware writes the lock registers over a simple single-cycle register bus. Once a lock bit is set, it blocks writes to, or reads of, one protected register until the next reset.

The lock storage is cleared only by the block's own reset input. Scan mode and the raw debug-unlock line have no path into the lock storage or into the access checks. The only way past a set lock is the authenticated-debug grant, which a trusted authority outside this block raises.

Writes take effect on the clock edge that samples them. Reads are combinational while the read strobe is high. An attempted write through a write lock raises a one-cycle violation pulse.

Top module: `secreg_bank`

## Requirements
- R1: After reset, all 24 protected registers and all 6 lock registers read as zero, and every address outside the map reads as zero.
- R2: A bus write to an unlocked protected register at addresses 0 to 23 stores the write data on that clock edge, and a read returns it.
- R3: While the write lock of a protected register is set and the authenticated grant is low, a write to that register is dropped and its value is held.
- R4: While the read lock of a protected register is set and the authenticated grant is low, a read of that register returns 16'h0000.
- R5: A write that R3 drops raises `access_viol` for exactly the cycle after the write edge. Any other write leaves it low.
- R6: A set lock bit stays set until reset. Writing zeros to a lock register does not clear any bit.
- R7: A write to lock register i at address 32+i (i from 0 to 5) ORs write-data bits [7:0] into that register, so it is write-one-to-set. A read of address 32+i returns the register zero-extended to 16 bits, with no lock applied.
- R8: `scan_mode` and `dbg_unlock_raw`, alone or together, neither clear any lock bit nor let a write or read pass a set lock.
- R9: While `dbg_auth_grant` is high, writes to and reads of protected registers ignore both lock bits.
- R10: Writes to unmapped addresses (24 to 31, 38 to 63) change no register.
- R11: `rst_n` low clears the lock and protected registers at once, without a clock. After `rst_n` rises, writes at the first two clock edges are dropped, and the third edge accepts them.
- R12: Protected register p is controlled by lock register p/4. Bit 2*(p%4) of that register is the write lock and bit 2*(p%4)+1 is the read lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_mode | input | 1 | Scan test mode indication; has no effect on access |
| dbg_unlock_raw | input | 1 | Unauthenticated debug unlock; has no effect on access |
| dbg_auth_grant | input | 1 | Authenticated debug grant; overrides locks |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high, zero otherwise |
| access_viol | output | 1 | One-cycle pulse after a write blocked by a write lock |

## Verification
The properties assume that the bus presents at most one access per cycle and that its inputs change only between edges. They also assume that `dbg_auth_grant` is a level held steady around the access it qualifies. The stimulus drives every input on the falling edge and never raises `bus_wr` and `bus_rd` together. It toggles `scan_mode` and `dbg_unlock_raw` only between accesses. It raises the grant only for a whole sweep, so each property sees stable qualifiers at the sampling edge.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int DATA_W        = 16;
  localparam int N_LOCKREG     = 6;
  localparam int PROT_PER_LOCK = 4;
  localparam int ADDR_W        = 6;
  localparam int LOCK_BASE     = 32;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_PROT = 2'd1,
    RGN_LOCK = 2'd2
  } region_e;
endpackage

// File: rtl/secreg_rst_sync.sv
module secreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/secreg_lock_store.sv
module secreg_lock_store #(
  parameter int N_LOCKREG = 6,
  parameter int LOCK_W    = 8,
  parameter int LIDX_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [LIDX_W-1:0]                idx,
  input  logic [LOCK_W-1:0]                wdata,
  output logic [N_LOCKREG-1:0][LOCK_W-1:0] lock_q
);
  logic [N_LOCKREG-1:0][LOCK_W-1:0] lock_d;

  // Sticky set-only update: bits can only be added, never removed, until reset.
  always_comb begin
    for (int i = 0; i < N_LOCKREG; i++) begin
      lock_d[i] = lock_q[i];
      if (we && (idx == LIDX_W'(i))) lock_d[i] = lock_q[i] | wdata;
    end
  end

  // Reset comes only from the synchronised power-on/system reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end
endmodule

// File: rtl/secreg_prot_file.sv
module secreg_prot_file #(
  parameter int NUM_PROT = 24,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_PROT-1:0][DATA_W-1:0] prot_q
);
  for (genvar k = 0; k < NUM_PROT; k++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = we && (idx == IDX_W'(k));
      d  = en ? wdata : prot_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prot_q[k] <= '0;
      else        prot_q[k] <= d;
    end
  end
endmodule

// File: rtl/secreg_access_ctl.sv
module secreg_access_ctl
  import secreg_pkg::*;
#(
  parameter int NUM_PROT  = 24,
  parameter int N_LOCKREG = 6,
  parameter int LOCK_W    = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int LOCK_BASE = 32,
  parameter int IDX_W     = 5,
  parameter int LIDX_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             auth,
  input  logic [NUM_PROT-1:0]              wlock,
  input  logic [NUM_PROT-1:0]              rlock,
  input  logic [NUM_PROT-1:0][DATA_W-1:0]  prot_q,
  input  logic [N_LOCKREG-1:0][LOCK_W-1:0] lock_q,
  output logic                             prot_we,
  output logic [IDX_W-1:0]                 prot_idx,
  output logic                             lock_we,
  output logic [LIDX_W-1:0]                lock_idx,
  output logic [DATA_W-1:0]                bus_rdata,
  output logic                             viol
);
  region_e           rgn;
  logic [ADDR_W-1:0] loff;
  logic              wl_sel, rl_sel;
  logic [DATA_W-1:0] pdata_sel;
  logic [LOCK_W-1:0] ldata_sel;
  logic              viol_d;

  always_comb begin
    loff     = bus_addr - ADDR_W'(LOCK_BASE);
    prot_idx = bus_addr[IDX_W-1:0];
    lock_idx = loff[LIDX_W-1:0];
    if (bus_addr < ADDR_W'(NUM_PROT))     rgn = RGN_PROT;
    else if (loff < ADDR_W'(N_LOCKREG))   rgn = RGN_LOCK;
    else                                  rgn = RGN_NONE;
  end

  always_comb begin
    wl_sel    = 1'b0;
    rl_sel    = 1'b0;
    pdata_sel = '0;
    for (int k = 0; k < NUM_PROT; k++) begin
      if (prot_idx == IDX_W'(k)) begin
        wl_sel    = wlock[k];
        rl_sel    = rlock[k];
        pdata_sel = prot_q[k];
      end
    end
    ldata_sel = '0;
    for (int i = 0; i < N_LOCKREG; i++) begin
      if (lock_idx == LIDX_W'(i)) ldata_sel = lock_q[i];
    end
  end

  // Only the authenticated grant overrides a lock; no other mode is consulted.
  always_comb begin
    prot_we = bus_wr && (rgn == RGN_PROT) && (!wl_sel || auth);
    lock_we = bus_wr && (rgn == RGN_LOCK);
    viol_d  = bus_wr && (rgn == RGN_PROT) && wl_sel && !auth;
    bus_rdata = '0;
    if (bus_rd) begin
      if (rgn == RGN_PROT) begin
        if (!rl_sel || auth) bus_rdata = pdata_sel;
      end else if (rgn == RGN_LOCK) begin
        bus_rdata = DATA_W'(ldata_sel);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= viol_d;
  end
endmodule

// File: rtl/secreg_bank.sv
module secreg_bank
  import secreg_pkg::*;
#(
  parameter int DATA_W_P        = secreg_pkg::DATA_W,
  parameter int N_LOCKREG_P     = secreg_pkg::N_LOCKREG,
  parameter int PROT_PER_LOCK_P = secreg_pkg::PROT_PER_LOCK,
  parameter int ADDR_W_P        = secreg_pkg::ADDR_W,
  parameter int LOCK_BASE_P     = secreg_pkg::LOCK_BASE,
  parameter int RST_STAGES      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_mode,
  input  logic                dbg_unlock_raw,
  input  logic                dbg_auth_grant,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W_P-1:0] bus_addr,
  input  logic [DATA_W_P-1:0] bus_wdata,
  output logic [DATA_W_P-1:0] bus_rdata,
  output logic                access_viol
);
  localparam int NUM_PROT = N_LOCKREG_P * PROT_PER_LOCK_P;
  localparam int LOCK_W   = 2 * PROT_PER_LOCK_P;
  localparam int IDX_W    = $clog2(NUM_PROT);
  localparam int LIDX_W   = $clog2(N_LOCKREG_P);

  logic                               rst_sync_n;
  logic [N_LOCKREG_P-1:0][LOCK_W-1:0] lock_q;
  logic [NUM_PROT-1:0][DATA_W_P-1:0]  prot_q;
  logic [NUM_PROT-1:0]                wlock, rlock;
  logic                               prot_we, lock_we;
  logic [IDX_W-1:0]                   prot_idx;
  logic [LIDX_W-1:0]                  lock_idx;

  secreg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  secreg_lock_store #(
    .N_LOCKREG (N_LOCKREG_P),
    .LOCK_W    (LOCK_W),
    .LIDX_W    (LIDX_W)
  ) u_locks (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (lock_we),
    .idx    (lock_idx),
    .wdata  (bus_wdata[LOCK_W-1:0]),
    .lock_q (lock_q)
  );

  // Fixed field layout: even bit = write lock, odd bit = read lock.
  for (genvar k = 0; k < NUM_PROT; k++) begin : g_lockmap
    assign wlock[k] = lock_q[k / PROT_PER_LOCK_P][2 * (k % PROT_PER_LOCK_P)];
    assign rlock[k] = lock_q[k / PROT_PER_LOCK_P][2 * (k % PROT_PER_LOCK_P) + 1];
  end

  secreg_prot_file #(
    .NUM_PROT (NUM_PROT),
    .DATA_W   (DATA_W_P),
    .IDX_W    (IDX_W)
  ) u_prot (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (prot_we),
    .idx    (prot_idx),
    .wdata  (bus_wdata),
    .prot_q (prot_q)
  );

  secreg_access_ctl #(
    .NUM_PROT  (NUM_PROT),
    .N_LOCKREG (N_LOCKREG_P),
    .LOCK_W    (LOCK_W),
    .DATA_W    (DATA_W_P),
    .ADDR_W    (ADDR_W_P),
    .LOCK_BASE (LOCK_BASE_P),
    .IDX_W     (IDX_W),
    .LIDX_W    (LIDX_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .auth      (dbg_auth_grant),
    .wlock     (wlock),
    .rlock     (rlock),
    .prot_q    (prot_q),
    .lock_q    (lock_q),
    .prot_we   (prot_we),
    .prot_idx  (prot_idx),
    .lock_we   (lock_we),
    .lock_idx  (lock_idx),
    .bus_rdata (bus_rdata),
    .viol      (access_viol)
  );
endmodule

// File: rtl/secreg_bank_chk.sv
module secreg_bank_chk #(
  parameter int DATA_W        = 16,
  parameter int N_LOCKREG     = 6,
  parameter int PROT_PER_LOCK = 4,
  parameter int ADDR_W        = 6,
  parameter int LOCK_BASE     = 32
) (
  input logic                                          clk,
  input logic                                          rst_sync_n,
  input logic                                          scan_mode,
  input logic                                          dbg_unlock_raw,
  input logic                                          auth,
  input logic                                          bus_wr,
  input logic                                          bus_rd,
  input logic [ADDR_W-1:0]                             bus_addr,
  input logic [DATA_W-1:0]                             bus_wdata,
  input logic [DATA_W-1:0]                             bus_rdata,
  input logic                                          viol,
  input logic [N_LOCKREG*PROT_PER_LOCK-1:0][DATA_W-1:0] prot_q,
  input logic [N_LOCKREG-1:0][2*PROT_PER_LOCK-1:0]     lock_q
);
  localparam int NUM_PROT = N_LOCKREG * PROT_PER_LOCK;
  localparam int LOCK_W   = 2 * PROT_PER_LOCK;

  logic wl_at, rl_at, blocked_wr;

  always_comb begin
    wl_at = 1'b0;
    rl_at = 1'b0;
    for (int k = 0; k < NUM_PROT; k++) begin
      if (bus_addr == ADDR_W'(k)) begin
        wl_at = lock_q[k / PROT_PER_LOCK][2 * (k % PROT_PER_LOCK)];
        rl_at = lock_q[k / PROT_PER_LOCK][2 * (k % PROT_PER_LOCK) + 1];
      end
    end
    blocked_wr = bus_wr && (bus_addr < ADDR_W'(NUM_PROT)) && wl_at && !auth;
  end

  for (genvar k = 0; k < NUM_PROT; k++) begin : g_prot
    // R3, R12
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (bus_wr && bus_addr == ADDR_W'(k) && lock_q[k / PROT_PER_LOCK][2 * (k % PROT_PER_LOCK)] && !auth)
      |=> $stable(prot_q[k]));
    // R2, R9
    a_r2_open_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (bus_wr && bus_addr == ADDR_W'(k) && (!lock_q[k / PROT_PER_LOCK][2 * (k % PROT_PER_LOCK)] || auth))
      |=> (prot_q[k] == $past(bus_wdata)));
  end

  // R4
  a_r4_read_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && (bus_addr < ADDR_W'(NUM_PROT)) && rl_at && !auth) |-> (bus_rdata == '0));

  // R5
  a_r5_viol_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blocked_wr |=> viol);
  a_r5_viol_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !blocked_wr |=> !viol);

  // R6
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R8
  a_r8_dbg_no_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scan_mode || dbg_unlock_raw) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  for (genvar i = 0; i < N_LOCKREG; i++) begin : g_lock
    // R7
    a_r7_set_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (bus_wr && bus_addr == ADDR_W'(LOCK_BASE + i))
      |=> (lock_q[i] == ($past(lock_q[i]) | $past(bus_wdata[LOCK_W-1:0]))));
  end
endmodule

bind secreg_bank secreg_bank_chk #(
  .DATA_W        (DATA_W_P),
  .N_LOCKREG     (N_LOCKREG_P),
  .PROT_PER_LOCK (PROT_PER_LOCK_P),
  .ADDR_W        (ADDR_W_P),
  .LOCK_BASE     (LOCK_BASE_P)
) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .scan_mode      (scan_mode),
  .dbg_unlock_raw (dbg_unlock_raw),
  .auth           (dbg_auth_grant),
  .bus_wr         (bus_wr),
  .bus_rd         (bus_rd),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .viol           (access_viol),
  .prot_q         (prot_q),
  .lock_q         (lock_q)
);

// File: tb/tb_secreg_bank.sv
module tb_secreg_bank;
  localparam int NP = 24;
  localparam int NL = 6;

  logic        clk = 1'b0;
  logic        rst_n, scan_mode, dbg_unlock_raw, dbg_auth_grant;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        access_viol;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] exp_prot [NP];
  logic [7:0]  exp_lock [NL];

  always #4 clk = ~clk;

  secreg_bank dut (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .dbg_unlock_raw(dbg_unlock_raw),
    .dbg_auth_grant(dbg_auth_grant), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .access_viol(access_viol)
  );

  function automatic logic [15:0] pat(input int k, input int s);
    return 16'((k * 16'h0ACE) ^ (s * 16'h5A5A) ^ 16'h8001);
  endfunction

  function automatic logic wl(input int k);
    return exp_lock[k / 4][2 * (k % 4)];
  endfunction

  function automatic logic rl(input int k);
    return exp_lock[k / 4][2 * (k % 4) + 1];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, output logic v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    v = access_viol;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic read_all(input string tag, input logic use_auth);
    logic [15:0] d;
    for (int k = 0; k < NP; k++) begin
      rd(6'(k), d);
      chk(tag, d, (rl(k) && !use_auth) ? 16'h0 : exp_prot[k]);
    end
    for (int i = 0; i < NL; i++) begin
      rd(6'(32 + i), d);
      chk(tag, d, {8'h0, exp_lock[i]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic        v;
    logic [15:0] d;
    rst_n = 1'b0; scan_mode = 1'b0; dbg_unlock_raw = 1'b0; dbg_auth_grant = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int k = 0; k < NP; k++) exp_prot[k] = '0;
    for (int i = 0; i < NL; i++) exp_lock[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, including unmapped space
    read_all("R1", 1'b0);
    for (int a = 24; a < 64; a++) begin
      if (a < 32 || a > 37) begin
        rd(6'(a), d);
        chk("R1 unmapped", d, 16'h0);
      end
    end

    // R2: open writes
    for (int k = 0; k < NP; k++) begin
      exp_prot[k] = pat(k, 1);
      wr(6'(k), exp_prot[k], v);
      chk("R5 open write no viol", {15'b0, v}, 16'h0);
    end
    read_all("R2", 1'b0);

    // R10: unmapped writes change nothing
    for (int a = 24; a < 64; a++) begin
      if (a < 32 || a > 37) wr(6'(a), 16'hFFFF, v);
    end
    read_all("R10", 1'b0);

    // R7, R12: set locks with varied masks
    for (int i = 0; i < NL; i++) begin
      logic [7:0] m;
      m = 8'((i * 8'h2D) + 8'h13);
      exp_lock[i] = exp_lock[i] | m;
      wr(6'(32 + i), {8'hFF, m}, v);
    end
    read_all("R7", 1'b0);

    // R6: zero writes do not clear; further ones accumulate (R7)
    for (int i = 0; i < NL; i++) wr(6'(32 + i), 16'h0000, v);
    read_all("R6", 1'b0);
    wr(6'(33), 16'h0001, v);
    exp_lock[1] = exp_lock[1] | 8'h01;
    rd(6'(33), d);
    chk("R7 accumulate", d, {8'h0, exp_lock[1]});

    // R3, R5, R8: locked writes under every scan/raw-unlock combination
    for (int mode = 0; mode < 4; mode++) begin
      for (int k = 0; k < NP; k++) begin
        @(negedge clk);
        scan_mode = mode[0]; dbg_unlock_raw = mode[1];
        wr(6'(k), pat(k, 2 + mode), v);
        if (!wl(k)) exp_prot[k] = pat(k, 2 + mode);
        chk(wl(k) ? "R5 blocked viol" : "R5 open viol", {15'b0, v}, {15'b0, wl(k)});
      end
      // R4, R8: read masking holds under the same modes
      read_all(mode == 0 ? "R3" : "R8", 1'b0);
    end
    scan_mode = 1'b0; dbg_unlock_raw = 1'b0;

    // R9: authenticated grant overrides both locks
    dbg_auth_grant = 1'b1;
    for (int k = 0; k < NP; k++) begin
      exp_prot[k] = pat(k, 9);
      wr(6'(k), exp_prot[k], v);
      chk("R9 no viol", {15'b0, v}, 16'h0);
    end
    read_all("R9", 1'b1);
    dbg_auth_grant = 1'b0;
    read_all("R4", 1'b0);

    // R11: asynchronous clear, then synchronous release
    @(negedge clk);
    #2 rst_n = 1'b0;
    bus_rd = 1'b1; bus_addr = 6'd32;
    #1 chk("R11 async clear", bus_rdata, 16'h0);
    bus_rd = 1'b0;
    for (int k = 0; k < NP; k++) exp_prot[k] = '0;
    for (int i = 0; i < NL; i++) exp_lock[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 16'hBEEF;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(6'd0, d);
    chk("R11 early write dropped", d, 16'h0);
    read_all("R11", 1'b0);
    exp_prot[0] = 16'h1234;
    wr(6'd0, 16'h1234, v);
    rd(6'd0, d);
    chk("R11 write after release", d, 16'h1234);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule